// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Control

This block holds the status byte of a serial flash memory and decides whether program, erase and status-write commands may proceed. It receives single-cycle strobes from an opcode decoder: write-enable, write-disable, write-status with a data byte, and read-status. It also receives signals from the program/erase sequencer: a level that shows an operation is running, a pulse when an ordinary program or erase finishes, and a pulse when an auto-increment programming run ends. An auto-increment mode level and an active-low hardware protect pin are the remaining inputs.

The block keeps three things in registers: the write-enable latch, the four-bit protection level and the lock bit. The busy flag and the auto-increment flag are shown live from their inputs. The status byte is always present on the output, and its read does not change any state. Two grant outputs are also produced. The first lets the decoder start a program or erase. The second says whether a status write presented now would take effect.

The write-enable latch clears itself after every completed modifying operation. The hardware pin and the lock bit together gate status writes. While the lock bit is set, the protection level is frozen even when a status write is accepted.

Top module: `flash_sr_top`

## Requirements
- R1: After reset, with `busyIn` and `aaiMode` low, `status` reads 8'h1C: latch 0, level 4'b0111, lock 0.
- R2: `status` bit 0 follows `busyIn` and bit 6 follows `aaiMode` in the same cycle. Bit 1 is the write-enable latch, bits 5:2 are the protection level (bit 2 is its LSB) and bit 7 is the lock bit.
- R3: `cmdWren` with `busyIn` low sets the latch on the next edge.
- R4: `cmdWrdi` with `busyIn` low clears the latch on the next edge.
- R5: `progGrant` is 1 exactly when the latch is 1 and `busyIn` is low.
- R6: A `seqDone` or `aaiDone` pulse clears the latch on the next edge, even when `busyIn` is high and even when it coincides with `cmdWren`.
- R7: `wrsrGrant` is 1 when `busyIn` is low and either `wpN` is 1 or the lock bit is 0. An accepted `cmdWrsr` loads the lock from `wrData[7]` and clears the latch.
- R8: `cmdWrsr` with `wpN` low and lock 1 is rejected: the level, the lock and the latch all keep their values.
- R9: While the lock is 1, an accepted `cmdWrsr` leaves the level unchanged. While the lock is 0, it loads the level from `wrData[5:2]`.
- R10: While `busyIn` is high, `cmdWren`, `cmdWrdi` and `cmdWrsr` change nothing. `cmdRdsr` never changes any state.
- R11: `wrData` bits 0, 1 and 6 never reach the status byte. Bits 0 and 6 always come from the inputs, and bit 1 is changed only by the latch rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (power-up) |
| cmdWren | input | 1 | Write-enable instruction strobe |
| cmdWrdi | input | 1 | Write-disable instruction strobe |
| cmdWrsr | input | 1 | Write-status instruction strobe |
| wrData | input | 8 | Data byte for the write-status instruction |
| cmdRdsr | input | 1 | Read-status instruction strobe |
| seqDone | input | 1 | Program or erase completion pulse |
| aaiDone | input | 1 | Auto-increment programming end pulse |
| busyIn | input | 1 | Internal program/erase in progress |
| aaiMode | input | 1 | Auto-increment programming mode active |
| wpN | input | 1 | Active-low hardware write-protect pin |
| status | output | 8 | Status byte |
| progGrant | output | 1 | Program/erase commands permitted |
| wrsrGrant | output | 1 | Status-register write permitted |

## Verification
The bench targets four corner cases.

- A completion pulse that lands on the same cycle as a write-enable must leave the latch cleared. A design that let the set win would leave the next program command wrongly allowed.
- With the pin low and the lock set, a rejected status write must keep the latch set. A design that cleared the latch anyway would refuse a program command the host had enabled.
- With the pin high and the lock set, a status write is accepted: the lock can be released, but the level must not move. A design that copied the level at that point would drop protection.
- Write strobes that arrive while busy, and any read, must leave every bit as it was.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int BpW     = 4;
  localparam int StatusW = BpW + 4;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadLock;
    logic loadLevel;
  } srStrobe_t;
endpackage

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWren,
  input  logic      cmdWrdi,
  input  logic      cmdWrsr,
  input  logic      cmdRdsr,
  input  logic      seqDone,
  input  logic      aaiDone,
  input  logic      busyIn,
  input  logic      wpN,
  input  logic      welQ,
  input  logic      lockQ,
  output srStrobe_t strobe,
  output logic      progGrant,
  output logic      wrsrGrant
);
  logic wrsrOk;
  logic anyDone;
  logic unusedRead;

  assign unusedRead = cmdRdsr;
  assign anyDone    = seqDone | aaiDone;
  assign wrsrOk     = !busyIn && (wpN || !lockQ);

  always_comb begin
    strobe           = '0;
    strobe.loadLock  = cmdWrsr && wrsrOk;
    strobe.loadLevel = cmdWrsr && wrsrOk && !lockQ;
    strobe.setWel    = cmdWren && !busyIn;
    strobe.clrWel    = anyDone || (cmdWrdi && !busyIn) || (cmdWrsr && wrsrOk);
  end

  assign progGrant = welQ && !busyIn;
  assign wrsrGrant = wrsrOk;

  p_wren_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWren && !busyIn && !anyDone && !cmdWrdi && !cmdWrsr) |=> welQ);

  p_wrdi_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrdi && !busyIn) |=> !welQ);

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyDone |=> !welQ);

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && !wpN && lockQ && !anyDone && !cmdWren && !cmdWrdi)
      |=> (lockQ && welQ == $past(welQ)));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !anyDone) |=> (welQ == $past(welQ) && lockQ == $past(lockQ)));

  p_read_no_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdsr && !cmdWren && !cmdWrdi && !cmdWrsr && !anyDone)
      |=> (welQ == $past(welQ) && lockQ == $past(lockQ)));
endmodule

// File: rtl/flash_sr_datapath.sv
module flash_sr_datapath
  import flash_sr_pkg::*;
#(
  parameter logic [BpW-1:0] LevelReset = 4'b0111
) (
  input  logic               clk,
  input  logic               rstN,
  input  srStrobe_t          strobe,
  input  logic [StatusW-1:0] wrData,
  input  logic               busyIn,
  input  logic               aaiMode,
  output logic               welQ,
  output logic               lockQ,
  output logic [StatusW-1:0] status
);
  localparam int LevelLsb = 2;
  localparam int LevelMsb = LevelLsb + BpW - 1;
  localparam int AaiPos   = LevelMsb + 1;
  localparam int LockPos  = AaiPos + 1;

  logic [BpW-1:0] levelQ;
  logic           unusedBits;

  assign unusedBits = ^{wrData[1:0], wrData[AaiPos]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
    end else if (strobe.clrWel) begin
      welQ <= 1'b0;
    end else if (strobe.setWel) begin
      welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
    end else if (strobe.loadLock) begin
      lockQ <= wrData[LockPos];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= LevelReset;
    end else if (strobe.loadLevel) begin
      levelQ <= wrData[LevelMsb:LevelLsb];
    end
  end

  always_comb begin
    status                    = '0;
    status[0]                 = busyIn;
    status[1]                 = welQ;
    status[LevelMsb:LevelLsb] = levelQ;
    status[AaiPos]            = aaiMode;
    status[LockPos]           = lockQ;
  end

  p_level_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> (levelQ == $past(levelQ)));

  p_level_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLevel |=> (levelQ == $past(wrData[LevelMsb:LevelLsb])));
endmodule

// File: rtl/flash_sr_top.sv
module flash_sr_top
  import flash_sr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWren,
  input  logic               cmdWrdi,
  input  logic               cmdWrsr,
  input  logic [StatusW-1:0] wrData,
  input  logic               cmdRdsr,
  input  logic               seqDone,
  input  logic               aaiDone,
  input  logic               busyIn,
  input  logic               aaiMode,
  input  logic               wpN,
  output logic [StatusW-1:0] status,
  output logic               progGrant,
  output logic               wrsrGrant
);
  srStrobe_t strobe;
  logic      welQ;
  logic      lockQ;

  flash_sr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr), .cmdRdsr(cmdRdsr),
    .seqDone(seqDone), .aaiDone(aaiDone), .busyIn(busyIn), .wpN(wpN),
    .welQ(welQ), .lockQ(lockQ),
    .strobe(strobe), .progGrant(progGrant), .wrsrGrant(wrsrGrant)
  );

  flash_sr_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .busyIn(busyIn), .aaiMode(aaiMode),
    .welQ(welQ), .lockQ(lockQ), .status(status)
  );

  p_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (progGrant == (status[1] && !busyIn)));
endmodule

// File: tb/test_flash_sr_top.sv
module test_flash_sr_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdRdsr = 0;
  logic       seqDone = 0, aaiDone = 0, busyIn = 0, aaiMode = 0, wpN = 1;
  logic [7:0] wrData = 8'h00;
  logic [7:0] status;
  logic       progGrant, wrsrGrant;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic       mWel = 0, mLock = 0;
  logic [3:0] mLevel = 4'b0111;

  always #2.5 clk = ~clk;

  flash_sr_top i_flash_sr_top (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrsr(cmdWrsr), .wrData(wrData), .cmdRdsr(cmdRdsr),
    .seqDone(seqDone), .aaiDone(aaiDone), .busyIn(busyIn),
    .aaiMode(aaiMode), .wpN(wpN), .status(status),
    .progGrant(progGrant), .wrsrGrant(wrsrGrant)
  );

  function automatic logic [7:0] expStatus();
    return {mLock, aaiMode, mLevel, mWel, busyIn};
  endfunction

  function automatic logic expWrsrOk();
    return !busyIn && (wpN || !mLock);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " status"}, status, expStatus());
    check({req, " R5 progGrant"}, {7'd0, progGrant}, {7'd0, mWel && !busyIn});
    check({req, " R7 wrsrGrant"}, {7'd0, wrsrGrant}, {7'd0, expWrsrOk()});
  endtask

  task automatic modelEdge();
    logic ok;
    logic clr;
    ok  = cmdWrsr && expWrsrOk();
    clr = seqDone || aaiDone || (cmdWrdi && !busyIn) || ok;
    if (ok && !mLock) mLevel = wrData[5:2];
    if (ok) mLock = wrData[7];
    if (clr) mWel = 1'b0;
    else if (cmdWren && !busyIn) mWel = 1'b1;
  endtask

  task automatic apply(string req, logic wren, logic wrdi, logic wrsr, logic rdsr,
                       logic [7:0] d, logic sdone, logic adone, logic busy,
                       logic aai, logic wp);
    @(negedge clk);
    cmdWren = wren; cmdWrdi = wrdi; cmdWrsr = wrsr; cmdRdsr = rdsr;
    wrData = d; seqDone = sdone; aaiDone = adone; busyIn = busy;
    aaiMode = aai; wpN = wp;
    #1;
    checkAll(req);
    @(posedge clk);
    modelEdge();
    #1;
    cmdWren = 0; cmdWrdi = 0; cmdWrsr = 0; cmdRdsr = 0; seqDone = 0; aaiDone = 0;
    #0.5;
    checkAll({req, " after"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset status", status, 8'h1C);
    check("R5 reset progGrant", {7'd0, progGrant}, 8'd0);
    rstN = 1'b1;

    // R2: live busy and aai bits
    apply("R2 live bits", 0, 0, 0, 1, 8'h00, 0, 0, 1, 1, 1);
    // R3: write-enable sets latch
    apply("R3 wren", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    check("R3 latch set", status, 8'h1E);
    // R10: write strobes ignored while busy
    apply("R10 wrdi busy", 0, 1, 0, 0, 8'h00, 0, 0, 1, 0, 1);
    apply("R10 wrsr busy", 0, 0, 1, 0, 8'hFF, 0, 0, 1, 0, 1);
    apply("R10 rdsr", 0, 0, 0, 1, 8'hFF, 0, 0, 0, 0, 0);
    check("R10 state held", status, 8'h1E);
    // R6: done beats wren
    apply("R6 done+wren", 1, 0, 0, 0, 8'h00, 1, 0, 0, 0, 1);
    check("R6 latch cleared", status, 8'h1C);
    apply("R3 wren again", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    apply("R6 aai end while busy", 0, 0, 0, 0, 8'h00, 0, 1, 1, 1, 1);
    // R4
    apply("R3 wren", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    apply("R4 wrdi", 0, 1, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    // R7, R11: accepted write, read-only bits ignored
    apply("R3 wren", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    apply("R7 R11 wrsr FF", 0, 0, 1, 0, 8'hFF, 0, 0, 0, 0, 1);
    check("R11 wrsr FF result", status, 8'hBC);
    // R8: rejected under pin+lock, latch kept
    apply("R3 wren", 1, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    apply("R8 wrsr rejected", 0, 0, 1, 0, 8'h00, 0, 0, 0, 0, 0);
    check("R8 held", status, 8'hBE);
    // R9: pin high, lock released, level frozen
    apply("R9 unlock", 0, 0, 1, 0, 8'h00, 0, 0, 0, 0, 1);
    check("R9 level frozen", status, 8'h3C);
    apply("R9 level load", 0, 0, 1, 0, 8'h14, 0, 0, 0, 0, 0);
    check("R9 level loaded", status, 8'h14);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 against model
    for (int i = 0; i < 3000; i++) begin
      int unsigned pick;
      logic [7:0] d;
      pick = $urandom_range(0, 9);
      d = 8'($urandom);
      apply("R2-mix random", pick == 0 || pick == 5, pick == 1, pick >= 6 && pick <= 8,
            pick == 2, d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 31) == 0),
            ($urandom_range(0, 3) == 0), 1'($urandom), ($urandom_range(0, 2) != 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule